// File: doc/BRIEF.md
# Register File with Instruction-Field Operand Override

This block is an eight-entry, 8-bit general register file with two combinational read ports (A and B) and one write-data bus. Each register has its own write line from microcode. For each read port, microcode supplies a register number directly. Three override flags let the register numbers come from fields of the current instruction word instead:

- a destination field picks the one register to write;
- a first source field picks the A operand;
- a second source field picks the B operand.

A single microinstruction can therefore serve any combination of registers. The sequencer names a field of the instruction word and does not spell out a register number.

Register 7 holds the program counter and register 6 holds a working copy of it. Microcode writes both through their explicit write lines. The block decodes the destination field into one-hot write enables. It also steers the selects, so that these effective controls drive the storage in place of the raw microcode lines.

Top module: `gpr_override_file`

## Requirements
- R1: A synchronous, active-high reset clears all eight registers to zero. After reset, every register reads 0 on both ports.
- R2: When `dst_ovr` is 1, only the register numbered by `ir_dst` is written with `wr_data` at the rising edge, and `uc_we` has no effect.
- R3: When `dst_ovr` is 0, every register n whose `uc_we[n]` bit is 1 is written with `wr_data` at the rising edge. Several registers may be written in one cycle, including register 7 (the program counter) and register 6 (its copy).
- R4: A register that is not enabled by the rule in force keeps its value across the edge.
- R5: `rd_a` shows the register numbered by `ir_src1` when `ovr_a` is 1, and the register numbered by `uc_sel_a` when `ovr_a` is 0.
- R6: `rd_b` shows the register numbered by `ir_src2` when `ovr_b` is 1, and the register numbered by `uc_sel_b` when `ovr_b` is 0.
- R7: Reads are combinational. During a cycle that writes a register, a read of that register returns the old value, and the new value appears only after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| uc_we | input | 8 | Microcode write line per register, bit n for register n |
| dst_ovr | input | 1 | Take the write target from the instruction destination field |
| uc_sel_a | input | 3 | Microcode register number for port A |
| ovr_a | input | 1 | Take the port A number from the first source field |
| uc_sel_b | input | 3 | Microcode register number for port B |
| ovr_b | input | 1 | Take the port B number from the second source field |
| ir_dst | input | 3 | Instruction destination field |
| ir_src1 | input | 3 | Instruction first source field |
| ir_src2 | input | 3 | Instruction second source field |
| wr_data | input | 8 | Write data bus |
| rd_a | output | 8 | Port A read data |
| rd_b | output | 8 | Port B read data |

## Verification
The hardest case to reach from the ports is a destination override while the microcode write lines are all active. A stray write under override only shows up when a register outside the destination field is read back later. The stimulus forces this case directly with every write line set, and then reads all eight registers. A second case is a read of the very register being written in the same cycle, and directed steps create it for both ports. Random stimulus, drawn from a fixed seed, biases each override flag to half the cycles. The microcode and instruction fields are drawn independently, so the override and direct paths disagree on nearly every cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_COUNT  = 8;
  localparam int GPR_DATA_W = 8;

  typedef enum logic {
    WSRC_UCODE = 1'b0,
    WSRC_INSTR = 1'b1
  } wr_src_e;
endpackage

// File: rtl/gpr_we_steer.sv
module gpr_we_steer #(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] uc_we,
  input  logic            dst_ovr,
  input  logic [IW-1:0]   ir_dst,
  output logic [NREG-1:0] eff_we
);
  import gpr_pkg::*;

  function automatic logic [NREG-1:0] idx_to_onehot(input logic [IW-1:0] idx);
    logic [NREG-1:0] v;
    v = '0;
    for (int k = 0; k < NREG; k++) v[k] = (idx == IW'(k));
    return v;
  endfunction

  wr_src_e         src;
  logic [NREG-1:0] dec_we;

  assign src    = dst_ovr ? WSRC_INSTR : WSRC_UCODE;
  assign dec_we = idx_to_onehot(ir_dst);

  always_comb begin
    unique case (src)
      WSRC_INSTR: eff_we = dec_we;
      default:    eff_we = uc_we;
    endcase
  end

  // R2: exactly one enable, the one named by the destination field
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    dst_ovr |-> ($countones(eff_we) == 1 && eff_we[ir_dst]));
endmodule

// File: rtl/gpr_port_sel.sv
module gpr_port_sel #(
  parameter int IW = 3
) (
  input  logic          ovr,
  input  logic [IW-1:0] ir_fld,
  input  logic [IW-1:0] uc_fld,
  output logic [IW-1:0] sel
);
  function automatic logic [IW-1:0] choose(input logic o,
                                           input logic [IW-1:0] a,
                                           input logic [IW-1:0] b);
    return o ? a : b;
  endfunction

  assign sel = choose(ovr, ir_fld, uc_fld);
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG-1:0]    we,
  input  logic [DW-1:0]      wdata,
  input  logic [IW-1:0]      sel_a,
  input  logic [IW-1:0]      sel_b,
  output logic [DW-1:0]      rdata_a,
  output logic [DW-1:0]      rdata_b,
  output logic [NREG*DW-1:0] contents
);
  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (we[g]) q[g] <= wdata;
    end
    assign contents[g*DW +: DW] = q[g];

    // R3: an enabled register captures the write bus
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> (q[g] == $past(wdata)));
    // R4: a register without an enable keeps its value
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      !we[g] |=> $stable(q[g]));
  end

  assign rdata_a = q[sel_a];
  assign rdata_b = q[sel_b];
endmodule

// File: rtl/gpr_override_file.sv
module gpr_override_file #(
  parameter int NREG = gpr_pkg::GPR_COUNT,
  parameter int DW   = gpr_pkg::GPR_DATA_W,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] uc_we,
  input  logic            dst_ovr,
  input  logic [IW-1:0]   uc_sel_a,
  input  logic            ovr_a,
  input  logic [IW-1:0]   uc_sel_b,
  input  logic            ovr_b,
  input  logic [IW-1:0]   ir_dst,
  input  logic [IW-1:0]   ir_src1,
  input  logic [IW-1:0]   ir_src2,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_a,
  output logic [DW-1:0]   rd_b
);
  logic [NREG-1:0]    eff_we;
  logic [IW-1:0]      eff_sel_a;
  logic [IW-1:0]      eff_sel_b;
  logic [NREG*DW-1:0] contents;

  gpr_we_steer #(.NREG(NREG)) u_steer (
    .clk(clk), .rst(rst), .uc_we(uc_we), .dst_ovr(dst_ovr),
    .ir_dst(ir_dst), .eff_we(eff_we)
  );

  gpr_port_sel #(.IW(IW)) u_sel_a (
    .ovr(ovr_a), .ir_fld(ir_src1), .uc_fld(uc_sel_a), .sel(eff_sel_a)
  );

  gpr_port_sel #(.IW(IW)) u_sel_b (
    .ovr(ovr_b), .ir_fld(ir_src2), .uc_fld(uc_sel_b), .sel(eff_sel_b)
  );

  gpr_array #(.NREG(NREG), .DW(DW)) u_array (
    .clk(clk), .rst(rst), .we(eff_we), .wdata(wr_data),
    .sel_a(eff_sel_a), .sel_b(eff_sel_b),
    .rdata_a(rd_a), .rdata_b(rd_b), .contents(contents)
  );

  // R1: reset empties the whole file
  a_r1_clear: assert property (@(posedge clk) rst |=> (contents == '0));
  // R5: port A data tracks the chosen register number
  a_r5_port_a: assert property (@(posedge clk) disable iff (rst)
    rd_a == contents[(ovr_a ? ir_src1 : uc_sel_a)*DW +: DW]);
  // R6: port B data tracks the chosen register number
  a_r6_port_b: assert property (@(posedge clk) disable iff (rst)
    rd_b == contents[(ovr_b ? ir_src2 : uc_sel_b)*DW +: DW]);
  // R2: under override, registers other than the target stay unchanged
  a_r2_no_stray: assert property (@(posedge clk) disable iff (rst)
    dst_ovr |=> ((contents ^ $past(contents)) &
                 ~({{(NREG-1)*DW{1'b0}}, {DW{1'b1}}} << ($past(ir_dst)*DW))) == '0);
endmodule

// File: tb/test_gpr_override_file.sv
module test_gpr_override_file;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] uc_we;
  logic       dst_ovr, ovr_a, ovr_b;
  logic [2:0] uc_sel_a, uc_sel_b, ir_dst, ir_src1, ir_src2;
  logic [7:0] wr_data;
  logic [7:0] rd_a, rd_b;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [8];

  always #10 clk = ~clk;

  gpr_override_file i_gpr_override_file (
    .clk(clk), .rst(rst), .uc_we(uc_we), .dst_ovr(dst_ovr),
    .uc_sel_a(uc_sel_a), .ovr_a(ovr_a), .uc_sel_b(uc_sel_b), .ovr_b(ovr_b),
    .ir_dst(ir_dst), .ir_src1(ir_src1), .ir_src2(ir_src2),
    .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b)
  );

  function automatic logic [2:0] want_idx(input logic o, input logic [2:0] f_ir,
                                          input logic [2:0] f_uc);
    if (o) return f_ir;
    return f_uc;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // drive one cycle, check the pre-edge reads, then update the model
  task automatic step(input string tag, input logic [7:0] we, input logic dov,
                      input logic [2:0] sa, input logic oa, input logic [2:0] sb,
                      input logic ob, input logic [2:0] d, input logic [2:0] s1,
                      input logic [2:0] s2, input logic [7:0] wd);
    @(negedge clk);
    uc_we = we; dst_ovr = dov; uc_sel_a = sa; ovr_a = oa; uc_sel_b = sb;
    ovr_b = ob; ir_dst = d; ir_src1 = s1; ir_src2 = s2; wr_data = wd;
    #2;
    chk({tag, " portA"}, rd_a, model[want_idx(oa, s1, sa)]);
    chk({tag, " portB"}, rd_b, model[want_idx(ob, s2, sb)]);
    @(posedge clk);
    if (dov) model[d] = wd;
    else for (int k = 0; k < 8; k++) if (we[k]) model[k] = wd;
  endtask

  // read every register through both ports without writing
  task automatic sweep(input string tag);
    for (int k = 0; k < 8; k++)
      step(tag, 8'h00, 1'b0, 3'(k), 1'b0, 3'(7 - k), 1'b0, 3'd0, 3'd0, 3'd0, 8'hEE);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; uc_we = '0; dst_ovr = 0; ovr_a = 0; ovr_b = 0;
    uc_sel_a = 0; uc_sel_b = 0; ir_dst = 0; ir_src1 = 0; ir_src2 = 0; wr_data = 0;
    for (int k = 0; k < 8; k++) model[k] = 8'hXX;
    do_reset();
    sweep("R1 reset");

    // R3: program counter and its copy written together by explicit lines
    step("R3 pc-pair", 8'hC0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd2, 3'd0, 3'd0, 8'h5A);
    sweep("R3/R4 after pc-pair");

    // R2: override with every microcode write line active
    step("R2 ovr all-we", 8'hFF, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd3, 3'd0, 3'd0, 8'h33);
    sweep("R2 no-stray");

    // R7: same-cycle read of the register being written returns old value
    step("R7 same-cycle", 8'h00, 1'b1, 3'd0, 1'b1, 3'd3, 1'b0, 3'd3, 3'd3, 3'd0, 8'hA1);
    step("R7 after-edge", 8'h00, 1'b0, 3'd3, 1'b0, 3'd3, 1'b0, 3'd0, 3'd0, 3'd0, 8'h00);

    // R5/R6: fields disagree with microcode selects
    step("R5 ovr_a", 8'h00, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd7, 3'd6, 8'h00);
    step("R6 ovr_b", 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0, 3'd7, 3'd3, 8'h00);

    // random mix covering R2..R7
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] we;
      we = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      step("R5/R6 random", we, 1'($urandom), 3'($urandom), 1'($urandom),
           3'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
           3'($urandom), 8'($urandom));
    end
    sweep("R4 final");

    do_reset();
    sweep("R1 second reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule